// File: doc/BRIEF.md
# BCD Seven-Segment Decoder Chain with Zero Suppression

The block turns binary-coded decimal digits into segment drive for seven-segment displays. Each digit cell decodes a 4-bit code, with D as the most significant bit, into the seven segments a to g. All sixteen input codes have a defined picture. A compile-time parameter sets the output polarity. With active-low outputs a lit segment is driven 0, which suits common-anode displays. With active-high outputs a lit segment is driven 1, which suits common-cathode displays.

Each cell has three control inputs and one control output. The blanking input turns every segment off. The lamp-test input lights every segment. The zero-suppress input darkens a cell that holds zero. The zero-suppress output tells the next lower cell that everything above it was blank.

The top module chains four cells, most significant digit first. The zero-suppress output of each cell feeds the zero-suppress input of the cell below it. In this way leading zeros of a multi-digit number stay dark while zeros inside the number are shown. A parameter can keep the least significant digit lit, so that a value of zero still shows a single "0".

Top module: `seg7_display_chain`

## Requirements
- R1: Segment vectors use bit 0 = a, bit 1 = b, up to bit 6 = g, and are given here as lit-segment patterns. Codes 0..9 show 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F in hex. So digit 6 lights segment a and digit 9 lights segment d.
- R2: Codes 10..15 show the fixed symbols 58, 4C, 62, 69, 78 and 00 in hex. Code 15 is fully dark.
- R3: With ACTIVE_LOW=1 each segment pin is the inverse of its lit pattern. With ACTIVE_LOW=0 each segment pin equals its lit pattern.
- R4: While blank_in_n is 0, every segment of every digit is dark and chain_out_n is 1, whatever the other inputs are.
- R5: While blank_in_n is 1 and lamp_test_n is 0, every segment of every digit is lit. Zero suppression has no effect in this state, and chain_out_n is 1.
- R6: With blanking and lamp test both inactive, a digit whose zero-suppress input is 0 and whose code is 0 is dark. Its zero-suppress output is then 0.
- R7: A digit's zero-suppress output is 1 whenever its code is nonzero or its zero-suppress input is 1. That digit then shows its normal symbol.
- R8: The zero-suppress input of the most significant digit is lead_in_n. Each lower digit takes the zero-suppress output of the digit above it. The result is that leading zeros are dark and zeros after the first nonzero digit are shown.
- R9: With KEEP_LSD=1 the least significant digit ignores suppression and always shows its code, so chain_out_n stays 1. With KEEP_LSD=0 it takes part in the chain, and chain_out_n is 0 exactly when all digits were zero-suppressed.
- R10: With lead_in_n at 1, zero suppression is off and every digit shows its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcd_in | input | 16 | Four 4-bit codes; bits 3:0 are the least significant digit |
| blank_in_n | input | 1 | Active-low blanking of all digits |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| lead_in_n | input | 1 | Active-low zero-suppress input to the most significant digit |
| seg_out | output | 28 | Seven segment pins per digit; digit i occupies bits 7i+6:7i |
| chain_out_n | output | 1 | Zero-suppress output of the least significant digit |

## Verification
The bench goes after four kinds of error:

- **Precedence between the controls.** The bench tries all eight combinations of the three controls on zero and nonzero values. A decoder that let zero suppression beat lamp test would leave some digits dark during a lamp test. One that let lamp test beat blanking would light a blanked display.
- **Zeros inside a number.** Values such as 0100 and 0050 catch a chain that does not stop at the first nonzero digit. Such a chain would also darken those inner zeros.
- **Least significant digit.** The value 0000 is run with both KEEP_LSD settings. This shows whether the last digit wrongly disappears, or wrongly stays lit.
- **Codes and polarity.** Each of the sixteen codes is placed in every digit position and read through both polarities. This catches a wrong glyph, including digits 6 and 9 missing their tails, as well as an inversion on the wrong variant.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

  localparam int SEG_W  = 7;
  localparam int CODE_W = 4;

  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [CODE_W-1:0] code_t;

  // Resolved drive mode of one digit after control precedence.
  typedef enum logic [1:0] {
    MODE_SHOW  = 2'd0,
    MODE_ZDARK = 2'd1,
    MODE_LAMP  = 2'd2,
    MODE_BLANK = 2'd3
  } drive_mode_e;

  localparam seg_t SEG_ALL_ON  = '1;
  localparam seg_t SEG_ALL_OFF = '0;

  // Lit-segment pattern, bit0 = a ... bit6 = g.
  function automatic seg_t glyph_of(input code_t c);
    seg_t s;
    case (c)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      4'd10:   s = 7'h58;
      4'd11:   s = 7'h4C;
      4'd12:   s = 7'h62;
      4'd13:   s = 7'h69;
      4'd14:   s = 7'h78;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

  // Precedence: blank, then lamp test, then zero suppression, then decode.
  function automatic drive_mode_e resolve_mode(input logic blank_n,
                                               input logic lamp_n,
                                               input logic zsup_n,
                                               input logic is_zero);
    drive_mode_e m;
    if (!blank_n)                m = MODE_BLANK;
    else if (!lamp_n)            m = MODE_LAMP;
    else if (!zsup_n && is_zero) m = MODE_ZDARK;
    else                         m = MODE_SHOW;
    return m;
  endfunction

endpackage

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
  import seg7_pkg::*;
(
  input  code_t code_i,
  output seg_t  glyph_o
);
  assign glyph_o = glyph_of(code_i);
endmodule

// File: rtl/seg7_mode_ctrl.sv
module seg7_mode_ctrl
  import seg7_pkg::*;
(
  input  logic        blank_n_i,
  input  logic        lamp_n_i,
  input  logic        zsup_in_n_i,
  input  code_t       code_i,
  output drive_mode_e mode_o,
  output logic        zsup_out_n_o
);
  logic is_zero;
  assign is_zero      = (code_i == '0);
  assign mode_o       = resolve_mode(blank_n_i, lamp_n_i, zsup_in_n_i, is_zero);
  assign zsup_out_n_o = (mode_o != MODE_ZDARK);
endmodule

// File: rtl/seg7_polarity.sv
module seg7_polarity
  import seg7_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  seg_t lit_i,
  output seg_t pin_o
);
  generate
    if (ACTIVE_LOW) begin : g_anode
      assign pin_o = ~lit_i;
    end else begin : g_cathode
      assign pin_o = lit_i;
    end
  endgenerate
endmodule

// File: rtl/seg7_digit.sv
module seg7_digit
  import seg7_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  code_t code_i,
  input  logic  blank_n_i,
  input  logic  lamp_n_i,
  input  logic  zsup_in_n_i,
  output seg_t  seg_o,
  output logic  zsup_out_n_o
);
  seg_t        glyph;
  seg_t        lit;
  drive_mode_e mode;

  seg7_glyph_rom u_rom (
    .code_i (code_i),
    .glyph_o(glyph)
  );

  seg7_mode_ctrl u_ctrl (
    .blank_n_i   (blank_n_i),
    .lamp_n_i    (lamp_n_i),
    .zsup_in_n_i (zsup_in_n_i),
    .code_i      (code_i),
    .mode_o      (mode),
    .zsup_out_n_o(zsup_out_n_o)
  );

  always_comb begin
    case (mode)
      MODE_BLANK: lit = SEG_ALL_OFF;
      MODE_LAMP:  lit = SEG_ALL_ON;
      MODE_ZDARK: lit = SEG_ALL_OFF;
      default:    lit = glyph;
    endcase
  end

  seg7_polarity #(.ACTIVE_LOW(ACTIVE_LOW)) u_pol (
    .lit_i(lit),
    .pin_o(seg_o)
  );
endmodule

// File: rtl/seg7_display_chain.sv
module seg7_display_chain
  import seg7_pkg::*;
#(
  parameter int N_DIGITS   = 4,
  parameter bit ACTIVE_LOW = 1'b1,
  parameter bit KEEP_LSD   = 1'b1
) (
  input  logic [N_DIGITS*CODE_W-1:0] bcd_in,
  input  logic                       blank_in_n,
  input  logic                       lamp_test_n,
  input  logic                       lead_in_n,
  output logic [N_DIGITS*SEG_W-1:0]  seg_out,
  output logic                       chain_out_n
);
  localparam int TOP = N_DIGITS - 1;

  // Named chain wires, observed by the checker.
  logic [N_DIGITS-1:0] zin_n;
  logic [N_DIGITS-1:0] zout_n;

  generate
    for (genvar i = 0; i < N_DIGITS; i++) begin : g_dig
      if (i == TOP) begin : g_lead
        assign zin_n[i] = lead_in_n;
      end else if (i == 0 && KEEP_LSD) begin : g_keep
        assign zin_n[i] = 1'b1;
      end else begin : g_link
        assign zin_n[i] = zout_n[i+1];
      end

      seg7_digit #(.ACTIVE_LOW(ACTIVE_LOW)) u_digit (
        .code_i      (bcd_in[i*CODE_W +: CODE_W]),
        .blank_n_i   (blank_in_n),
        .lamp_n_i    (lamp_test_n),
        .zsup_in_n_i (zin_n[i]),
        .seg_o       (seg_out[i*SEG_W +: SEG_W]),
        .zsup_out_n_o(zout_n[i])
      );
    end
  endgenerate

  assign chain_out_n = zout_n[0];
endmodule

// File: rtl/seg7_chain_checker.sv
module seg7_chain_checker
  import seg7_pkg::*;
#(
  parameter int N_DIGITS   = 4,
  parameter bit ACTIVE_LOW = 1'b1,
  parameter bit KEEP_LSD   = 1'b1
) (
  input logic [N_DIGITS*CODE_W-1:0] bcd_in,
  input logic                       blank_in_n,
  input logic                       lamp_test_n,
  input logic                       lead_in_n,
  input logic [N_DIGITS*SEG_W-1:0]  seg_out,
  input logic                       chain_out_n,
  input logic [N_DIGITS-1:0]        zin_n,
  input logic [N_DIGITS-1:0]        zout_n
);
  localparam seg_t DARK = ACTIVE_LOW ? SEG_ALL_ON : SEG_ALL_OFF;
  localparam seg_t LIT  = ACTIVE_LOW ? SEG_ALL_OFF : SEG_ALL_ON;

  always_comb begin
    for (int i = 0; i < N_DIGITS; i++) begin
      // R4
      a_r4_blank_dark: assert (blank_in_n || seg_out[i*SEG_W +: SEG_W] == DARK)
        else $error("blanked digit %0d not dark", i);
      // R5
      a_r5_lamp_lit: assert (!blank_in_n || lamp_test_n
                             || seg_out[i*SEG_W +: SEG_W] == LIT)
        else $error("lamp test digit %0d not lit", i);
      // R6
      a_r6_zero_dark: assert (zout_n[i] || (seg_out[i*SEG_W +: SEG_W] == DARK
                              && bcd_in[i*CODE_W +: CODE_W] == '0 && !zin_n[i]))
        else $error("suppressed digit %0d inconsistent", i);
      // R7
      a_r7_out_high: assert (zout_n[i] || (blank_in_n && lamp_test_n))
        else $error("zero-suppress out low under override, digit %0d", i);
    end
    // R10
    a_r10_lead_off: assert (!lead_in_n || chain_out_n)
      else $error("suppression active with lead_in_n high");
    // R9
    a_r9_keep_lsd: assert (!KEEP_LSD || chain_out_n)
      else $error("kept digit reported as suppressed");
  end
endmodule

bind seg7_display_chain seg7_chain_checker #(
  .N_DIGITS  (N_DIGITS),
  .ACTIVE_LOW(ACTIVE_LOW),
  .KEEP_LSD  (KEEP_LSD)
) u_chk (
  .bcd_in     (bcd_in),
  .blank_in_n (blank_in_n),
  .lamp_test_n(lamp_test_n),
  .lead_in_n  (lead_in_n),
  .seg_out    (seg_out),
  .chain_out_n(chain_out_n),
  .zin_n      (zin_n),
  .zout_n     (zout_n)
);

// File: tb/seg7_display_chain_test.sv
module seg7_display_chain_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [15:0] bcd;
  logic        bl_n, lt_n, ld_n;
  logic [27:0] seg_a, seg_c;
  logic        co_a, co_c;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Lit patterns from R1/R2, bit0 = a.
  localparam logic [6:0] GLY [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h58, 7'h4C, 7'h62, 7'h69, 7'h78, 7'h00};

  // {blank_n, lamp_n, lead_n, bcd[15:0]}
  localparam int NV = 20;
  localparam logic [18:0] VEC [NV] = '{
    {3'b110, 16'h0000}, {3'b110, 16'h0007}, {3'b110, 16'h0100},
    {3'b110, 16'h0050}, {3'b110, 16'h1000}, {3'b110, 16'h9876},
    {3'b110, 16'h0A0F}, {3'b111, 16'h0000}, {3'b111, 16'h0012},
    {3'b100, 16'h0000}, {3'b100, 16'h1234}, {3'b101, 16'h0000},
    {3'b010, 16'h0000}, {3'b011, 16'h5678}, {3'b000, 16'h0100},
    {3'b110, 16'h00F0}, {3'b110, 16'hFFFF}, {3'b110, 16'h0001},
    {3'b111, 16'hBCDE}, {3'b110, 16'h0009}};

  seg7_display_chain #(.N_DIGITS(4), .ACTIVE_LOW(1'b1), .KEEP_LSD(1'b1)) uut (
    .bcd_in(bcd), .blank_in_n(bl_n), .lamp_test_n(lt_n), .lead_in_n(ld_n),
    .seg_out(seg_a), .chain_out_n(co_a));

  seg7_display_chain #(.N_DIGITS(4), .ACTIVE_LOW(1'b0), .KEEP_LSD(1'b0)) uut_cc (
    .bcd_in(bcd), .blank_in_n(bl_n), .lamp_test_n(lt_n), .lead_in_n(ld_n),
    .seg_out(seg_c), .chain_out_n(co_c));

  // Independent model: walk from most significant digit, carrying a flag.
  task automatic model(input bit keep, input bit act_low,
                       output logic [27:0] s, output logic c);
    logic run_dark;
    logic [6:0] lit;
    run_dark = !ld_n;
    for (int d = 3; d >= 0; d--) begin
      logic [3:0] code;
      code = bcd[d*4 +: 4];
      if (d == 0 && keep) run_dark = 1'b0;
      if (!bl_n)                      begin lit = 7'h00; run_dark = 1'b0; end
      else if (!lt_n)                 begin lit = 7'h7F; run_dark = 1'b0; end
      else if (run_dark && code == 0) lit = 7'h00;
      else                            begin lit = GLY[code]; run_dark = 1'b0; end
      s[d*7 +: 7] = act_low ? ~lit : lit;
    end
    c = !run_dark;
  endtask

  task automatic check(input string req);
    logic [27:0] es;
    logic        ec;
    model(1'b1, 1'b1, es, ec);
    n_chk++;
    if (seg_a !== es) begin
      n_fail++;
      $display("FAIL %s anode seg: got %h expected %h", req, seg_a, es);
    end
    n_chk++;
    if (co_a !== ec) begin
      n_fail++;
      $display("FAIL %s anode chain_out: got %b expected %b", req, co_a, ec);
    end
    model(1'b0, 1'b0, es, ec);
    n_chk++;
    if (seg_c !== es) begin
      n_fail++;
      $display("FAIL %s cathode seg: got %h expected %h", req, seg_c, es);
    end
    n_chk++;
    if (co_c !== ec) begin
      n_fail++;
      $display("FAIL %s cathode chain_out: got %b expected %b", req, co_c, ec);
    end
  endtask

  task automatic apply(input logic b, input logic l, input logic z,
                       input logic [15:0] v, input string req);
    @(negedge clk);
    bl_n = b; lt_n = l; ld_n = z; bcd = v;
    #2;
    check(req);
  endtask

  initial begin
    bl_n = 1'b0; lt_n = 1'b1; ld_n = 1'b1; bcd = 16'h0000;
    repeat (3) @(posedge clk);
    // Reset-time state: blanked display (R4).
    #2 check("R4_reset");
    rst = 1'b0;

    // Vector table: R6 R7 R8 R10 mixes.
    for (int k = 0; k < NV; k++)
      apply(VEC[k][18], VEC[k][17], VEC[k][16], VEC[k][15:0], "R8_vector");

    // Every code in every position, suppression off and on (R1 R2 R3).
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 16; c++) begin
        apply(1'b1, 1'b1, 1'b1, 16'h8888 & ~(16'hF << (p*4)) | (16'(c) << (p*4)), "R1_R2_R3_code");
        apply(1'b1, 1'b1, 1'b0, 16'(c) << (p*4), "R6_R7_code");
      end

    // All control combinations, several values (R4 R5 R9 R10).
    for (int m = 0; m < 8; m++) begin
      apply(m[2], m[1], m[0], 16'h0000, "R4_R5_R9_ctrl");
      apply(m[2], m[1], m[0], 16'h0304, "R4_R5_R10_ctrl");
      apply(m[2], m[1], m[0], 16'h0000 | 16'h0020, "R5_R6_ctrl");
    end

    // Directed: digit 6 and 9 tails (R1), code 15 dark (R2), lsd keep (R9).
    apply(1'b1, 1'b1, 1'b1, 16'h6969, "R1_tails");
    apply(1'b1, 1'b1, 1'b0, 16'h000F, "R2_code15");
    apply(1'b1, 1'b1, 1'b0, 16'h0000, "R9_all_zero");
    apply(1'b1, 1'b0, 1'b0, 16'h0000, "R5_lamp_over_zero");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule